// File: doc/BRIEF.md
# Frame Field Compare Filter Bank

This block sits beside a receive datapath and watches the bytes of each incoming Ethernet frame as they arrive, one byte per accepted cycle. A single shared window, set by a starting byte offset and a byte count, selects a field of the frame. For example, with offset 6 and count 6 the window is the source address. Eight compare slots then judge that field. Each slot holds its own 48-bit reference value, a 48-bit don't-care mask and a relational mode: off, equal, greater-than or less-than.

At the end of every frame the bank produces an 8-bit hit vector, one bit per slot, together with a one-cycle valid strobe. The vector stays put until the next frame begins. A small write-only register port loads the references, masks, window and modes. Software is expected to change the configuration only between frames.

Top module: `frame_field_cmp_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every configuration register is cleared, so all slots are off. From the next cycle `hit_vec` is 0 and `hit_valid` is 0.
- R2: A write with `cfg_we` high updates one register at the next clock edge. For slot n, address 4n+0 is the low 32 bits of the reference and 4n+1 holds the high 16 bits in `cfg_wdata[15:0]`. Address 4n+2 is the low 32 bits of the mask and 4n+3 holds the high 16 bits in `cfg_wdata[15:0]`. Address 32 is the window register and address 33 is the mode register.
- R3: In the window register, bits 14:0 give the start offset and bits 19:16 give the length. The byte that carries `rx_sof` is frame position 0. Window byte k (frame position start+k) lands in bits 8k+7:8k of a 48-bit field. Window bytes beyond the sixth are not stored. Unfilled field bytes read as zero, and a length of 0 gives an all-zero field that is always complete.
- R4: A mask bit of 1 removes that bit from both the field and the reference before the compare. A mask of all zeros is an exact compare.
- R5: Mode code 1 (equal) hits when the masked field equals the masked reference.
- R6: Mode code 2 (greater-than) hits when the masked field, read as an unsigned number with the first received window byte least significant, exceeds the masked reference.
- R7: Mode code 3 (less-than) hits when the masked field is below the masked reference under the same unsigned ordering.
- R8: The mode register holds slot n's 2-bit code in bits 2n+1:2n. Code 0 (off) never hits, whatever the reference and mask.
- R9: One cycle after an accepted byte that carries `rx_eof`, `hit_valid` is high for exactly one cycle and `hit_vec[n]` gives slot n's result. `hit_vec` then holds its value until the next frame starts.
- R10: If the frame ends before the last window position (start+length-1) has been received, `hit_vec` is 0 for that frame.
- R11: An accepted byte with `rx_sof` and no `rx_eof` clears `hit_vec` on the next cycle. A byte that carries both markers is a one-byte frame whose result is reported as in R9.
- R12: Bytes with `rx_valid` high that arrive after an end marker and before the next start marker are ignored. They do not change `hit_vec` and do not shift the frame positions of the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A frame byte is present on `rx_data` |
| rx_sof | input | 1 | The present byte is the first of a frame |
| rx_eof | input | 1 | The present byte is the last of a frame |
| rx_data | input | 8 | Frame byte |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address |
| cfg_wdata | input | 32 | Register write data |
| hit_vec | output | 8 | Per-slot result of the last finished frame |
| hit_valid | output | 1 | One-cycle strobe when `hit_vec` has been updated at end of frame |

## Verification
The bench gives one configuration that mixes all four modes and several masks, then sends three frames whose windows equal, exceed and fall below a reference. This separates equal, greater-than and less-than in every slot at once. In one of these frames the first window byte is raised and the last is lowered. The result is only correct if the first byte is the least significant, so a reversed byte order shows up. Frames that end one byte before and exactly at the last window position pin down the truncation rule. A window longer than six bytes and a zero-length window with a one-byte frame cover the length corners. Stray bytes between frames and a frame that is started but not yet finished show whether positions and the held result survive.

// File: rtl/fcb_pkg.sv
// Shared definitions for the frame field compare bank.
// Assumes: mode codes are fixed by the register encoding and are not remapped.
package fcb_pkg;
    localparam int FIELD_BYTES = 6;
    localparam int FIELD_W     = 8 * FIELD_BYTES;
    localparam int START_W     = 15;
    localparam int LEN_W       = 4;

    typedef enum logic [1:0] {
        CMP_OFF = 2'd0,
        CMP_EQ  = 2'd1,
        CMP_GT  = 2'd2,
        CMP_LT  = 2'd3
    } cmp_mode_e;
endpackage

// File: rtl/fcb_cfg_regs.sv
// Write-only configuration store: per-slot reference and mask, shared window, modes.
// Assumes: slot words at 4n+sel, window at 2^(AW-1), modes at 2^(AW-1)+1.
module fcb_cfg_regs
    import fcb_pkg::*;
#(
    parameter int NSLOT = 8,
    localparam int SLOT_AW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int AW      = SLOT_AW + 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [AW-1:0]                  addr,
    input  logic [31:0]                    wdata,
    output logic [NSLOT-1:0][FIELD_W-1:0]  ref_val,
    output logic [NSLOT-1:0][FIELD_W-1:0]  ref_msk,
    output logic [START_W-1:0]             win_start,
    output logic [LEN_W-1:0]               win_len,
    output logic [2*NSLOT-1:0]             mode_bits
);
    logic glob_sel;
    assign glob_sel = addr[AW-1];

    for (genvar n = 0; n < NSLOT; n++) begin : g_slot
        logic slot_hit;
        assign slot_hit = we && !glob_sel && (addr[AW-2:2] == SLOT_AW'(n));

        // Load one word of this slot's reference or mask.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ref_val[n] <= '0;
                ref_msk[n] <= '0;
            end else if (slot_hit) begin
                case (addr[1:0])
                    2'd0: ref_val[n][31:0]         <= wdata;
                    2'd1: ref_val[n][FIELD_W-1:32] <= wdata[FIELD_W-33:0];
                    2'd2: ref_msk[n][31:0]         <= wdata;
                    default: ref_msk[n][FIELD_W-1:32] <= wdata[FIELD_W-33:0];
                endcase
            end
        end
    end

    // Load the shared window and the packed mode word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_start <= '0;
            win_len   <= '0;
            mode_bits <= '0;
        end else if (we && glob_sel && (addr[AW-2:0] == '0)) begin
            win_start <= wdata[START_W-1:0];
            win_len   <= wdata[16 +: LEN_W];
        end else if (we && glob_sel && (addr[AW-2:0] == (AW-1)'(1))) begin
            mode_bits <= wdata[2*NSLOT-1:0];
        end
    end
endmodule

// File: rtl/fcb_window_capture.sv
// Tracks frame position and gathers the window bytes into a little-endian field.
// Assumes: rx_sof marks position 0; bytes outside a frame are dropped.
// Outputs include the byte presented in the current cycle.
module fcb_window_capture
    import fcb_pkg::*;
#(
    parameter int POS_W = 16,
    localparam int EXT_W = POS_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic                 rx_sof,
    input  logic                 rx_eof,
    input  logic [7:0]           rx_data,
    input  logic [START_W-1:0]   win_start,
    input  logic [LEN_W-1:0]     win_len,
    output logic                 take,
    output logic [FIELD_W-1:0]   field_now,
    output logic                 field_done
);
    logic [POS_W-1:0]   pos_q;
    logic [FIELD_W-1:0] field_q;
    logic               in_frame_q;
    logic [POS_W-1:0]   cur_pos;
    logic [EXT_W-1:0]   pos_x, st_x, end_x, idx;
    logic               in_win;

    assign take    = rx_valid && (rx_sof || in_frame_q);
    assign cur_pos = rx_sof ? '0 : pos_q;
    assign pos_x   = EXT_W'(cur_pos);
    assign st_x    = EXT_W'(win_start);
    assign end_x   = st_x + EXT_W'(win_len);
    assign idx     = pos_x - st_x;
    assign in_win  = (pos_x >= st_x) && (pos_x < end_x);

    // Merge the present byte into the field at its window slot.
    always_comb begin
        field_now = rx_sof ? '0 : field_q;
        for (int k = 0; k < FIELD_BYTES; k++) begin
            if (take && in_win && (idx == EXT_W'(k))) field_now[8*k +: 8] = rx_data;
        end
    end

    // Window complete once its last position is at or before the present byte.
    assign field_done = (win_len == '0) || (pos_x + EXT_W'(1) >= end_x);

    // Advance position, keep gathered bytes and frame membership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q      <= '0;
            field_q    <= '0;
            in_frame_q <= 1'b0;
        end else if (take) begin
            pos_q      <= cur_pos + POS_W'(cur_pos != '1);
            field_q    <= field_now;
            in_frame_q <= !rx_eof;
        end
    end
endmodule

// File: rtl/fcb_slot_cmp.sv
// One compare slot: masks field and reference, then applies the relational mode.
// Assumes: mask bit 1 = don't care; unsigned compare of the packed field.
module fcb_slot_cmp
    import fcb_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    input  logic [FIELD_W-1:0] ref_val,
    input  logic [FIELD_W-1:0] ref_msk,
    input  logic [1:0]         mode,
    output logic               hit
);
    logic [FIELD_W-1:0] f_m, r_m;
    assign f_m = field   & ~ref_msk;
    assign r_m = ref_val & ~ref_msk;

    // Select the relation named by the mode code.
    always_comb begin
        case (cmp_mode_e'(mode))
            CMP_EQ:  hit = (f_m == r_m);
            CMP_GT:  hit = (f_m >  r_m);
            CMP_LT:  hit = (f_m <  r_m);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/frame_field_cmp_bank.sv
// Top: eight masked relational compares on a programmable window of each frame.
// Assumes: configuration is stable while a frame is in flight.
module frame_field_cmp_bank
    import fcb_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int POS_W = 16,
    localparam int SLOT_AW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int AW      = SLOT_AW + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [NSLOT-1:0] hit_vec,
    output logic             hit_valid
);
    logic [NSLOT-1:0][FIELD_W-1:0] ref_val, ref_msk;
    logic [START_W-1:0]            win_start;
    logic [LEN_W-1:0]              win_len;
    logic [2*NSLOT-1:0]            mode_flat;
    logic                          take, field_done;
    logic [FIELD_W-1:0]            field_now;
    logic [NSLOT-1:0]              slot_hits;

    fcb_cfg_regs #(.NSLOT(NSLOT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ref_val(ref_val), .ref_msk(ref_msk), .win_start(win_start),
        .win_len(win_len), .mode_bits(mode_flat)
    );

    fcb_window_capture #(.POS_W(POS_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .win_start(win_start),
        .win_len(win_len), .take(take), .field_now(field_now), .field_done(field_done)
    );

    for (genvar n = 0; n < NSLOT; n++) begin : g_cmp
        fcb_slot_cmp u_slot (
            .field(field_now), .ref_val(ref_val[n]), .ref_msk(ref_msk[n]),
            .mode(mode_flat[2*n +: 2]), .hit(slot_hits[n])
        );
    end

    // Latch results at end of frame, clear them at start of frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_vec   <= '0;
            hit_valid <= 1'b0;
        end else begin
            hit_valid <= take && rx_eof;
            if (take && rx_eof)      hit_vec <= field_done ? slot_hits : '0;
            else if (take && rx_sof) hit_vec <= '0;
        end
    end
endmodule

// File: rtl/fcb_checker.sv
// Temporal checks on the compare bank's result interface, bound to the top.
// Assumes: mode word observed is the one the slots used at the end byte.
module fcb_checker #(
    parameter int NSLOT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rx_sof,
    input logic             rx_eof,
    input logic [2*NSLOT-1:0] mode_flat,
    input logic [NSLOT-1:0] hit_vec,
    input logic             hit_valid
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (hit_vec == '0 && !hit_valid));

    // R9
    strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> $past(rx_valid && rx_eof));

    // R9
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && (rx_sof || rx_eof)) |=> $stable(hit_vec));

    // R11
    sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof && !rx_eof) |=> (hit_vec == '0));

    for (genvar n = 0; n < NSLOT; n++) begin : g_off
        // R8
        off_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_valid && $past(mode_flat[2*n +: 2]) == 2'd0) |-> !hit_vec[n]);
    end
endmodule

bind frame_field_cmp_bank fcb_checker #(.NSLOT(NSLOT)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .mode_flat(mode_flat), .hit_vec(hit_vec), .hit_valid(hit_valid)
);

// File: tb/frame_field_cmp_bank_tb.sv
// Bench: behavioural reference model compared every cycle, plus named checks.
module frame_field_cmp_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  hit_vec;
    logic        hit_valid;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [7:0] fb[$];

    // reference model state
    logic [47:0] m_val[8], m_msk[8];
    int          m_start = 0, m_len = 0;
    logic [15:0] m_mode = '0;
    bit          m_inf = 0;
    logic [7:0]  m_q[$];
    logic [7:0]  e_vec = '0;
    bit          e_valid = 0;

    frame_field_cmp_bank u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hit_vec(hit_vec), .hit_valid(hit_valid)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] model_eval();
        logic [47:0] w = '0;
        logic [7:0]  r = '0;
        if (m_len != 0 && m_q.size() < m_start + m_len) return 8'h00;
        for (int k = 0; k < m_len && k < 6; k++) w[8*k +: 8] = m_q[m_start + k];
        for (int s = 0; s < 8; s++) begin
            logic [47:0] a, b;
            a = w & ~m_msk[s];
            b = m_val[s] & ~m_msk[s];
            case (m_mode[2*s +: 2])
                2'd1: r[s] = (a == b);
                2'd2: r[s] = (a > b);
                2'd3: r[s] = (a < b);
                default: r[s] = 1'b0;
            endcase
        end
        return r;
    endfunction

    // Reference model: advances on each clock edge from the sampled inputs.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int s = 0; s < 8; s++) begin m_val[s] = '0; m_msk[s] = '0; end
            m_start = 0; m_len = 0; m_mode = '0; m_inf = 0; m_q.delete();
            e_vec = '0; e_valid = 0;
        end else begin
            e_valid = 0;
            if (rx_valid && (rx_sof || m_inf)) begin
                if (rx_sof) begin m_q.delete(); e_vec = '0; end
                m_q.push_back(rx_data);
                if (rx_eof) begin e_vec = model_eval(); e_valid = 1; m_inf = 0; end
                else m_inf = 1;
            end
            if (cfg_we) begin
                if (cfg_addr == 6'd32) begin
                    m_start = int'(cfg_wdata[14:0]); m_len = int'(cfg_wdata[19:16]);
                end else if (cfg_addr == 6'd33) m_mode = cfg_wdata[15:0];
                else if (cfg_addr < 6'd32) begin
                    case (cfg_addr[1:0])
                        2'd0: m_val[cfg_addr[4:2]][31:0]  = cfg_wdata;
                        2'd1: m_val[cfg_addr[4:2]][47:32] = cfg_wdata[15:0];
                        2'd2: m_msk[cfg_addr[4:2]][31:0]  = cfg_wdata;
                        default: m_msk[cfg_addr[4:2]][47:32] = cfg_wdata[15:0];
                    endcase
                end
            end
        end
    end

    // Per-cycle comparison of the outputs against the model (R9 timing).
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (hit_vec !== e_vec || hit_valid !== e_valid) begin
                n_fail++;
                $display("FAIL R9 model cyc %0d: vec=%h valid=%b expected vec=%h valid=%b",
                         cyc, hit_vec, hit_valid, e_vec, e_valid);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc > 50000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: expired, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_slot(input int s, input logic [47:0] v, input logic [47:0] m);
        wr(4*s + 0, v[31:0]);
        wr(4*s + 1, {16'h0, v[47:32]});
        wr(4*s + 2, m[31:0]);
        wr(4*s + 3, {16'h0, m[47:32]});
    endtask

    task automatic make_frame(input int len);
        fb.delete();
        for (int i = 0; i < len; i++) fb.push_back(8'((i * 7 + 3) & 255));
    endtask

    // Sends bytes [from, to) of fb; sof on byte 0, eof on last byte when asked.
    task automatic send(input int from, input int to, input bit with_eof);
        for (int i = from; i < to; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = fb[i];
            rx_sof = (i == 0); rx_eof = with_eof && (i == to - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    initial begin
        logic [47:0] wa;
        repeat (3) @(negedge clk);
        chk(hit_vec, 8'h00, "R1 vec after reset");
        chk({7'b0, hit_valid}, 8'h00, "R1 valid after reset");
        rst_n = 1'b1;

        // frame A window (bytes 6..11) = 50_49_42_3B_34_2D
        wa = 48'h50_49_42_3B_34_2D;
        wr(32, 32'h0006_0006);
        set_slot(0, wa, 48'h0);
        set_slot(1, wa ^ 48'hFF_00_00_00_00_00, 48'hFF_00_00_00_00_00);
        set_slot(2, wa - 48'd1, 48'h0);
        set_slot(3, wa + 48'd1, 48'h0);
        set_slot(4, wa, 48'h0);
        set_slot(5, wa ^ 48'h1, 48'h0);
        set_slot(6, wa, 48'h0);
        set_slot(7, wa, 48'h0);
        wr(33, 32'h0000_E4E5);

        make_frame(20);
        send(0, 20, 1);
        chk(hit_vec, 8'h0F, "R5 R4 R8 equal window frame");

        fb[6] = 8'hFF; fb[11] = 8'h4F;
        send(0, 20, 1);
        chk(hit_vec, 8'h88, "R7 R6 low byte up, high byte down");

        fb[6] = 8'h00; fb[11] = 8'h51;
        send(0, 20, 1);
        chk(hit_vec, 8'h44, "R6 greater window frame");

        make_frame(20);
        send(0, 11, 1);
        chk(hit_vec, 8'h00, "R10 ends one byte before window end");
        send(0, 12, 1);
        chk(hit_vec, 8'h0F, "R10 ends exactly at window end");

        send(0, 3, 0);
        chk(hit_vec, 8'h00, "R11 start of frame clears");
        send(3, 20, 1);
        chk(hit_vec, 8'h0F, "R11 frame finished after pause");

        // stray bytes between frames
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'hA5; rx_sof = 1'b0; rx_eof = (i == 2);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0;
        chk(hit_vec, 8'h0F, "R12 stray bytes leave result");
        send(0, 20, 1);
        chk(hit_vec, 8'h0F, "R12 positions unaffected by stray bytes");

        wr(33, 32'h0);
        send(0, 20, 1);
        chk(hit_vec, 8'h00, "R8 all slots off");

        // long window: start 2, length 8, only bytes 2..7 stored
        wr(32, 32'h0008_0002);
        set_slot(0, {fb[7], fb[6], fb[5], fb[4], fb[3], fb[2]}, 48'h0);
        wr(33, 32'h0000_0001);
        send(0, 9, 1);
        chk(hit_vec, 8'h00, "R3 R10 long window incomplete");
        send(0, 10, 1);
        chk(hit_vec, 8'h01, "R3 long window complete");

        // zero length window, one byte frame
        wr(32, 32'h0000_0005);
        set_slot(0, 48'h0, 48'h0);
        send(0, 1, 1);
        chk(hit_vec, 8'h01, "R3 empty window one-byte frame");

        // full mask makes any field equal
        wr(32, 32'h0006_0006);
        set_slot(0, 48'h1234_5678_9ABC, 48'hFFFF_FFFF_FFFF);
        send(0, 20, 1);
        chk(hit_vec, 8'h01, "R4 full mask");
        set_slot(0, 48'h1234_5678_9ABC, 48'h0);
        send(0, 20, 1);
        chk(hit_vec, 8'h00, "R2 R5 rewritten mask word");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule